// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This unit settles every control-transfer instruction of a 32-bit integer core in one place. For each instruction it receives the instruction's own address, the two source operand values, a small operation code, the raw offset field (sign bit included) and the destination register index. From these it decides whether control moves and where to. It also produces the return address that a jump writes back, and it flags a target that the fetch stage could not use because of its alignment.

Six ordered or equality comparisons drive the conditional forms. A conditional branch and the PC-relative jump both count their offset in halfwords from the instruction address. The register-indirect jump adds an unscaled byte offset to source A and clears bit 0 of the result. The greater-than and less-or-equal forms do not have codes of their own: the caller swaps the two sources and uses an ordered code. Plain jump, jump-register and return are the two jump codes with destination register 0. By default the result is held in an output register, so it appears one cycle after the inputs. A parameter removes the register and makes the unit purely combinational. A second parameter says whether 16-bit instructions exist, and the alignment rule follows it.

Top module: `brj_unit`

## Requirements
- R1: While `rst_ni` is low, all outputs are zero. With the default output register, each result appears on the outputs in the cycle after the inputs that produced it.
- R2: Operation codes: 0 none, 1 equal, 2 not-equal, 3 signed less-than, 4 signed greater-or-equal, 5 unsigned less-than, 6 unsigned greater-or-equal, 7 PC-relative jump, 8 register-indirect jump. Codes 9 to 15 behave as code 0. Code 1 transfers when A equals B. Code 2 transfers when they differ.
- R3: Codes 3 and 4 compare A against B as two's-complement numbers, so 0x80000000 and 0xFFFFFFFF both rank below 0.
- R4: Codes 5 and 6 compare A against B as unsigned numbers, so 0x80000000 and 0xFFFFFFFF both rank above 0.
- R5: For codes 1 to 6, `target_o` is pc + 2 × sign-extended `imm_i[11:0]`, whether or not the branch transfers. `imm_i[19:12]` has no effect on it, so the reach is −4096 to +4094 bytes.
- R6: Code 7 always transfers to pc + 2 × sign-extended `imm_i[19:0]`, which is −1,048,576 to +1,048,574 bytes away. The sum wraps modulo 2^32.
- R7: Code 8 always transfers to src_a + sign-extended `imm_i[11:0]`, with no scaling and with bit 0 of the sum forced to 0.
- R8: For codes 7 and 8, `link_value_o` is pc + 4. `link_valid_o` is 1 only when `rd_i` is not 0 and the target is not misaligned. For every other code, both outputs are 0.
- R9: A transfer that would happen but whose target is misaligned gives `misaligned_o`=1, `taken_o`=0 and `link_valid_o`=0, and `target_o` still holds the faulting address. Without 16-bit instruction support (the default), misaligned means target bits [1:0] are not 00. With that support, it means target bit 0 is 1.
- R10: A conditional branch that does not transfer, and codes 0 and 9 to 15, never raise `misaligned_o`. For codes 0 and 9 to 15, `taken_o`=0 and `target_o` is pc + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code (see R2) |
| pc_i | input | 32 | Address of the instruction being resolved |
| src_a_i | input | 32 | First source operand |
| src_b_i | input | 32 | Second source operand |
| imm_i | input | 20 | Raw offset field, sign bit at the top of the field used |
| rd_i | input | 5 | Destination register index of a jump |
| taken_o | output | 1 | Control transfers to target_o |
| target_o | output | 32 | Computed target or next sequential address |
| link_valid_o | output | 1 | link_value_o is to be written to rd |
| link_value_o | output | 32 | Return address of a jump |
| misaligned_o | output | 1 | Instruction-address-misaligned condition |

## Verification
The comparisons are driven with equal operands, which separates the strict codes from the inclusive ones. They are also driven with 0x80000000 and 0xFFFFFFFF against 0 in both orders. These values rank differently under signed and unsigned ordering, so they expose a comparison of the wrong kind, and the swapped-operand pairs show that A and B are not interchanged. The extreme offsets at both ends of the branch and jump ranges test sign extension and scaling. A branch offset with junk in bits above 11 shows that those bits are ignored. Odd halfword offsets and a register-indirect sum ending in binary 10 or 11 are run on one instance with 16-bit instruction support and one without, and so show both alignment rules and the clearing of bit 0. Random operations then run against the behavioural model on every clock.

// File: rtl/brj_pkg.sv
package brj_pkg;

    typedef enum logic [3:0] {
        BRJ_NONE = 4'd0,
        BRJ_EQ   = 4'd1,
        BRJ_NE   = 4'd2,
        BRJ_LT   = 4'd3,
        BRJ_GE   = 4'd4,
        BRJ_LTU  = 4'd5,
        BRJ_GEU  = 4'd6,
        BRJ_JAL  = 4'd7,
        BRJ_JALR = 4'd8
    } brj_op_e;

    localparam int unsigned BR_OFF_W  = 12;  // conditional / indirect offset field
    localparam int unsigned JAL_OFF_W = 20;  // PC-relative jump offset field
    localparam int unsigned RIDX_W    = 5;   // register index width

    function automatic logic is_branch(input brj_op_e op);
        return (op == BRJ_EQ) || (op == BRJ_NE) || (op == BRJ_LT) ||
               (op == BRJ_GE) || (op == BRJ_LTU) || (op == BRJ_GEU);
    endfunction

    function automatic logic is_jump(input brj_op_e op);
        return (op == BRJ_JAL) || (op == BRJ_JALR);
    endfunction

endpackage

// File: rtl/brj_compare.sv
module brj_compare
    import brj_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  brj_op_e          op_i,
    input  logic [XLEN-1:0]  a_i,
    input  logic [XLEN-1:0]  b_i,
    output logic             cond_o
);

    logic eq, lt_s, lt_u;

    always_comb begin
        eq   = (a_i == b_i);
        lt_s = ($signed(a_i) < $signed(b_i));
        lt_u = (a_i < b_i);
    end

    always_comb begin
        unique case (op_i)
            BRJ_EQ:   cond_o = eq;
            BRJ_NE:   cond_o = ~eq;
            BRJ_LT:   cond_o = lt_s;
            BRJ_GE:   cond_o = ~lt_s;
            BRJ_LTU:  cond_o = lt_u;
            BRJ_GEU:  cond_o = ~lt_u;
            BRJ_JAL,
            BRJ_JALR: cond_o = 1'b1;
            default:  cond_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/brj_target.sv
module brj_target
    import brj_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  brj_op_e                 op_i,
    input  logic [XLEN-1:0]         pc_i,
    input  logic [XLEN-1:0]         a_i,
    input  logic [JAL_OFF_W-1:0]    imm_i,
    output logic [XLEN-1:0]         target_o,
    output logic [XLEN-1:0]         seq_o
);

    localparam int unsigned BR_EXT  = XLEN - BR_OFF_W;
    localparam int unsigned JAL_EXT = XLEN - JAL_OFF_W - 1;
    localparam int unsigned BR_SEXT = XLEN - BR_OFF_W - 1;
    localparam logic [XLEN-1:0] CLR_B0 = ~XLEN'(1);
    localparam logic [XLEN-1:0] INSN_B = XLEN'(4);

    logic [XLEN-1:0] br_off;   // halfword-scaled branch offset
    logic [XLEN-1:0] jal_off;  // halfword-scaled jump offset
    logic [XLEN-1:0] ind_off;  // unscaled indirect offset
    logic [XLEN-1:0] ind_sum;

    always_comb begin
        br_off  = {{BR_SEXT{imm_i[BR_OFF_W-1]}}, imm_i[BR_OFF_W-1:0], 1'b0};
        jal_off = {{JAL_EXT{imm_i[JAL_OFF_W-1]}}, imm_i, 1'b0};
        ind_off = {{BR_EXT{imm_i[BR_OFF_W-1]}}, imm_i[BR_OFF_W-1:0]};
        ind_sum = a_i + ind_off;
        seq_o   = pc_i + INSN_B;
        if (is_branch(op_i)) begin
            target_o = pc_i + br_off;
        end else if (op_i == BRJ_JAL) begin
            target_o = pc_i + jal_off;
        end else if (op_i == BRJ_JALR) begin
            target_o = ind_sum & CLR_B0;
        end else begin
            target_o = seq_o;
        end
    end

endmodule

// File: rtl/brj_align.sv
module brj_align #(
    parameter bit HAS_HALF_INSN = 1'b0
) (
    input  logic [1:0] addr_lo_i,
    output logic       bad_o
);

    localparam logic [1:0] CHECK_MASK = HAS_HALF_INSN ? 2'b01 : 2'b11;

    always_comb begin
        bad_o = |(addr_lo_i & CHECK_MASK);
    end

endmodule

// File: rtl/brj_unit.sv
module brj_unit
    import brj_pkg::*;
#(
    parameter int unsigned XLEN          = 32,
    parameter bit          HAS_HALF_INSN = 1'b0,
    parameter bit          OUT_REG       = 1'b1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [3:0]            op_i,
    input  logic [XLEN-1:0]       pc_i,
    input  logic [XLEN-1:0]       src_a_i,
    input  logic [XLEN-1:0]       src_b_i,
    input  logic [JAL_OFF_W-1:0]  imm_i,
    input  logic [RIDX_W-1:0]     rd_i,
    output logic                  taken_o,
    output logic [XLEN-1:0]       target_o,
    output logic                  link_valid_o,
    output logic [XLEN-1:0]       link_value_o,
    output logic                  misaligned_o
);

    typedef struct packed {
        logic            taken;
        logic [XLEN-1:0] target;
        logic            link_valid;
        logic [XLEN-1:0] link_value;
        logic            misaligned;
    } res_t;

    brj_op_e         op;
    logic            cond;
    logic            bad_addr;
    logic [XLEN-1:0] tgt;
    logic [XLEN-1:0] seq;
    res_t            res_d;
    res_t            res_q;

    assign op = brj_op_e'(op_i);

    brj_compare #(.XLEN(XLEN)) u_cmp (
        .op_i   (op),
        .a_i    (src_a_i),
        .b_i    (src_b_i),
        .cond_o (cond)
    );

    brj_target #(.XLEN(XLEN)) u_tgt (
        .op_i     (op),
        .pc_i     (pc_i),
        .a_i      (src_a_i),
        .imm_i    (imm_i),
        .target_o (tgt),
        .seq_o    (seq)
    );

    brj_align #(.HAS_HALF_INSN(HAS_HALF_INSN)) u_aln (
        .addr_lo_i (tgt[1:0]),
        .bad_o     (bad_addr)
    );

    always_comb begin
        res_d            = '0;
        res_d.target     = tgt;
        res_d.misaligned = cond & bad_addr;
        res_d.taken      = cond & ~bad_addr;
        if (is_jump(op)) begin
            res_d.link_value = seq;
            res_d.link_valid = (rd_i != '0) & ~bad_addr;
        end
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    res_q <= '0;
                end else begin
                    res_q <= res_d;
                end
            end
        end else begin : g_comb
            assign res_q = rst_ni ? res_d : '0;
        end
    endgenerate

    assign taken_o      = res_q.taken;
    assign target_o     = res_q.target;
    assign link_valid_o = res_q.link_valid;
    assign link_value_o = res_q.link_value;
    assign misaligned_o = res_q.misaligned;

endmodule

// File: rtl/brj_unit_chk.sv
module brj_unit_chk
    import brj_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter bit          OUT_REG = 1'b1
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [3:0]      op_i,
    input logic [XLEN-1:0] pc_i,
    input logic            taken_o,
    input logic [XLEN-1:0] target_o,
    input logic            link_valid_o,
    input logic [XLEN-1:0] link_value_o,
    input logic            misaligned_o
);

    logic armed_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    // R9: a redirect and a misalignment flag never coexist
    a_r9_no_taken_and_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(taken_o && misaligned_o));

    // R8: a link write only accompanies a real redirect
    a_r8_link_needs_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_valid_o |-> taken_o);

    generate
        if (OUT_REG) begin : g_seq
            // R8: return address is the instruction after the jump
            a_r8_link_value: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
                link_valid_o |-> (link_value_o == $past(pc_i) + XLEN'(4)));

            // R6: jumps always resolve, either taken or faulting
            a_r6_jump_resolves: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
                ($past(op_i) == 4'd7 || $past(op_i) == 4'd8) |-> (taken_o || misaligned_o));

            // R7: indirect target never has bit 0 set
            a_r7_jalr_even: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
                ($past(op_i) == 4'd8) |-> !target_o[0]);

            // R10: no-op codes stay quiet
            a_r10_none_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
                ($past(op_i) == 4'd0) |-> (!taken_o && !misaligned_o && !link_valid_o));
        end else begin : g_comb
            // R7: indirect target never has bit 0 set
            a_r7_jalr_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_i == 4'd8) |-> !target_o[0]);

            // R10: no-op code stays quiet
            a_r10_none_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (op_i == 4'd0) |-> (!taken_o && !misaligned_o && !link_valid_o && link_value_o == '0));
        end
    endgenerate

endmodule

bind brj_unit brj_unit_chk #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_i         (op_i),
    .pc_i         (pc_i),
    .taken_o      (taken_o),
    .target_o     (target_o),
    .link_valid_o (link_valid_o),
    .link_value_o (link_value_o),
    .misaligned_o (misaligned_o)
);

// File: tb/brj_unit_test.sv
module brj_unit_test;

    typedef struct packed {
        logic        taken;
        logic [31:0] target;
        logic        link_valid;
        logic [31:0] link_value;
        logic        misaligned;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] pc = 32'h0;
    logic [31:0] a = 32'h0;
    logic [31:0] b = 32'h0;
    logic [19:0] imm = 20'h0;
    logic [4:0]  rd = 5'd0;

    logic        tk0, lv0, mi0, tk1, lv1, mi1;
    logic [31:0] tg0, lk0, tg1, lk1;

    int n_checks = 0;
    int n_fail   = 0;

    exp_t  q0[$];
    exp_t  q1[$];
    string qtag[$];

    always #5 clk = ~clk;

    // default: no 16-bit instructions
    brj_unit uut (
        .clk_i(clk), .rst_ni(rst_n), .op_i(op), .pc_i(pc), .src_a_i(a), .src_b_i(b),
        .imm_i(imm), .rd_i(rd), .taken_o(tk0), .target_o(tg0), .link_valid_o(lv0),
        .link_value_o(lk0), .misaligned_o(mi0)
    );

    brj_unit #(.HAS_HALF_INSN(1'b1)) uut_half (
        .clk_i(clk), .rst_ni(rst_n), .op_i(op), .pc_i(pc), .src_a_i(a), .src_b_i(b),
        .imm_i(imm), .rd_i(rd), .taken_o(tk1), .target_o(tg1), .link_valid_o(lv1),
        .link_value_o(lk1), .misaligned_o(mi1)
    );

    function automatic exp_t model(input logic [3:0] o, input logic [31:0] p, input logic [31:0] sa,
                                   input logic [31:0] sb, input logic [19:0] im, input logic [4:0] r,
                                   input bit half);
        exp_t e;
        bit c;
        bit bad;
        logic [31:0] t;
        int off12;
        int off20;
        off12 = int'($signed(im[11:0]));
        off20 = int'($signed(im));
        case (o)
            4'd1: c = (sa == sb);
            4'd2: c = (sa != sb);
            4'd3: c = ($signed(sa) <  $signed(sb));
            4'd4: c = ($signed(sa) >= $signed(sb));
            4'd5: c = (sa <  sb);
            4'd6: c = (sa >= sb);
            4'd7, 4'd8: c = 1'b1;
            default: c = 1'b0;
        endcase
        if (o >= 4'd1 && o <= 4'd6) t = p + 32'(off12 * 2);
        else if (o == 4'd7)         t = p + 32'(off20 * 2);
        else if (o == 4'd8)         t = (sa + 32'(off12)) & 32'hFFFF_FFFE;
        else                        t = p + 32'd4;
        bad = half ? t[0] : (t[1:0] != 2'b00);
        e.target     = t;
        e.taken      = c && !bad;
        e.misaligned = c && bad;
        if (o == 4'd7 || o == 4'd8) begin
            e.link_value = p + 32'd4;
            e.link_valid = (r != 5'd0) && !bad;
        end else begin
            e.link_value = 32'h0;
            e.link_valid = 1'b0;
        end
        return e;
    endfunction

    task automatic compare_one(input exp_t e, input logic t, input logic [31:0] g, input logic l,
                               input logic [31:0] k, input logic m, input string tag, input string who);
        n_checks++;
        if (t !== e.taken || g !== e.target || l !== e.link_valid || k !== e.link_value || m !== e.misaligned) begin
            n_fail++;
            $display("FAIL %s [%s] actual taken=%0b tgt=%h lv=%0b lk=%h mis=%0b expected taken=%0b tgt=%h lv=%0b lk=%h mis=%0b",
                     tag, who, t, g, l, k, m, e.taken, e.target, e.link_valid, e.link_value, e.misaligned);
        end
    endtask

    task automatic check_pending();
        exp_t e0;
        exp_t e1;
        string tg;
        if (q0.size() != 0) begin
            e0 = q0.pop_front();
            e1 = q1.pop_front();
            tg = qtag.pop_front();
            compare_one(e0, tk0, tg0, lv0, lk0, mi0, tg, "full");
            compare_one(e1, tk1, tg1, lv1, lk1, mi1, tg, "half");
        end
    endtask

    task automatic step(input logic [3:0] o, input logic [31:0] p, input logic [31:0] sa,
                        input logic [31:0] sb, input logic [19:0] im, input logic [4:0] r, input string tag);
        @(negedge clk);
        check_pending();
        op = o; pc = p; a = sa; b = sb; imm = im; rd = r;
        q0.push_back(model(o, p, sa, sb, im, r, 1'b0));
        q1.push_back(model(o, p, sa, sb, im, r, 1'b1));
        qtag.push_back(tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: outputs held at zero in reset, even with a jump on the inputs
        op = 4'd7; rd = 5'd1; pc = 32'h100;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            n_checks++;
            if ({tk0, tg0, lv0, lk0, mi0, tk1, tg1, lv1, lk1, mi1} !== '0) begin
                n_fail++;
                $display("FAIL R1 reset outputs actual tg=%h lk=%h expected 0", tg0, lk0);
            end
        end
        op = 4'd0; rd = 5'd0; pc = 32'h0;
        rst_n = 1'b1;
        q0.push_back(model(4'd0, 32'h0, 32'h0, 32'h0, 20'h0, 5'd0, 1'b0));
        q1.push_back(model(4'd0, 32'h0, 32'h0, 32'h0, 20'h0, 5'd0, 1'b1));
        qtag.push_back("R10 idle after reset");

        // R2 equality
        step(4'd1, 32'h4000, 32'd5, 32'd5, 20'h010, 5'd0, "R2 eq equal");
        step(4'd1, 32'h4000, 32'd5, 32'd6, 20'h010, 5'd0, "R2 eq differ");
        step(4'd2, 32'h4000, 32'd5, 32'd6, 20'h010, 5'd0, "R2 ne differ");
        step(4'd2, 32'h4000, 32'd7, 32'd7, 20'h010, 5'd0, "R2 ne equal");
        // R3 / R4 signed vs unsigned boundaries
        step(4'd3, 32'h4000, 32'h8000_0000, 32'h0, 20'h020, 5'd0, "R3 lt minint<0");
        step(4'd5, 32'h4000, 32'h8000_0000, 32'h0, 20'h020, 5'd0, "R4 ltu 0x80000000<0");
        step(4'd3, 32'h4000, 32'hFFFF_FFFF, 32'h0, 20'h020, 5'd0, "R3 lt -1<0");
        step(4'd5, 32'h4000, 32'hFFFF_FFFF, 32'h0, 20'h020, 5'd0, "R4 ltu ones<0");
        step(4'd4, 32'h4000, 32'hFFFF_FFFF, 32'h0, 20'h020, 5'd0, "R3 ge -1>=0");
        step(4'd6, 32'h4000, 32'hFFFF_FFFF, 32'h0, 20'h020, 5'd0, "R4 geu ones>=0");
        step(4'd3, 32'h4000, 32'h0, 32'h8000_0000, 20'h020, 5'd0, "R3 swapped gt");
        step(4'd5, 32'h4000, 32'h0, 32'h8000_0000, 20'h020, 5'd0, "R4 swapped gtu");
        step(4'd3, 32'h4000, 32'd9, 32'd9, 20'h020, 5'd0, "R3 lt equal");
        step(4'd4, 32'h4000, 32'd9, 32'd9, 20'h020, 5'd0, "R3 ge equal");
        step(4'd6, 32'h4000, 32'd9, 32'd9, 20'h020, 5'd0, "R4 geu equal");
        // R5 branch reach and ignored upper bits
        step(4'd1, 32'h4000, 32'd1, 32'd1, 20'h007FF, 5'd0, "R5 max forward");
        step(4'd1, 32'h4000, 32'd1, 32'd1, 20'h00800, 5'd0, "R5 max backward");
        step(4'd1, 32'h4000, 32'd1, 32'd1, 20'hFF002, 5'd0, "R5 upper bits ignored");
        step(4'd2, 32'h4000, 32'd1, 32'd1, 20'hAB006, 5'd0, "R5 not-taken target");
        // R9 / R10 odd halfword branch offset
        step(4'd1, 32'h4000, 32'd3, 32'd3, 20'h00001, 5'd0, "R9 taken odd offset");
        step(4'd1, 32'h4000, 32'd3, 32'd4, 20'h00001, 5'd0, "R10 not-taken odd offset");
        // R6 PC-relative jump
        step(4'd7, 32'h0010_0000, 32'h0, 32'h0, 20'h7FFFF, 5'd1, "R6 max forward");
        step(4'd7, 32'h0010_0000, 32'h0, 32'h0, 20'h80000, 5'd1, "R6 max backward");
        step(4'd7, 32'hFFFF_F000, 32'h0, 32'h0, 20'h01000, 5'd5, "R6 wrap");
        step(4'd7, 32'h0000_2000, 32'h0, 32'h0, 20'h00003, 5'd1, "R9 jal odd halfword");
        step(4'd7, 32'h0000_2000, 32'h0, 32'h0, 20'h00010, 5'd0, "R8 rd zero no link");
        // R7 register-indirect
        step(4'd8, 32'h3000, 32'h0000_1000, 32'h0, 20'h007FF, 5'd1, "R7 odd sum cleared");
        step(4'd8, 32'h3000, 32'h0000_1000, 32'h0, 20'h00800, 5'd1, "R7 negative offset");
        step(4'd8, 32'h3000, 32'h0000_2003, 32'h0, 20'h00001, 5'd1, "R7 unaligned base");
        step(4'd8, 32'h3000, 32'h0000_2001, 32'h0, 20'h00000, 5'd0, "R7 return form");
        step(4'd8, 32'h3000, 32'h0000_2000, 32'h0, 20'hFF004, 5'd2, "R7 upper bits ignored");
        // R10 none / undefined codes
        step(4'd0, 32'h5000, 32'd1, 32'd1, 20'h00001, 5'd1, "R10 none");
        step(4'd12, 32'h5000, 32'd1, 32'd1, 20'h00001, 5'd1, "R10 undefined code");

        for (int i = 0; i < 600; i++) begin
            logic [3:0]  ro;
            logic [31:0] rp, ra, rb;
            string t;
            ro = 4'($urandom_range(0, 10));
            rp = $urandom & 32'hFFFF_FFFE;
            ra = $urandom;
            rb = ($urandom_range(0, 3) == 0) ? ra : $urandom;
            case (ro)
                4'd1, 4'd2: t = "R2 random";
                4'd3, 4'd4: t = "R3 random";
                4'd5, 4'd6: t = "R4 random";
                4'd7:       t = "R6 random";
                4'd8:       t = "R7 random";
                default:    t = "R10 random";
            endcase
            step(ro, rp, ra, rb, 20'($urandom), 5'($urandom), t);
        end
        @(negedge clk);
        check_pending();
        finish_run();
    end

endmodule